// File: doc/BRIEF.md
# Half-Band Two-Times Interpolator

This block doubles the sample rate of one 10-bit sample stream that feeds a DAC. A new input code arrives on every second clock, marked by a strobe. The block writes one filtered output code on every clock. The filter is a linear-phase, 43-tap half-band FIR whose coefficients are fixed integers. The output alternates between two polyphase results. The first is a symmetric 22-tap weighted sum. The second is the sample that sits in the middle of the history, delayed and passed through unchanged, because the centre tap is the only non-zero tap in that phase.

Codes are offset binary on both sides. The block converts them to two's complement internally. It accumulates at full precision, rounds, clamps to the 10-bit range and converts back. The latency is fixed, and the block holds no state beyond the sample history and a three-stage arithmetic pipeline.

Top module: `halfband_interp2`

## Requirements
- R1: A synchronous active-low reset clears the sample history and the pipeline. While reset is held, and afterwards until the first strobed sample reaches the output, `out_code` is 512 (mid-scale).
- R2: `in_valid` is high for exactly one clock in every two, and each high clock captures one input code. `out_code` takes a new value on every clock. The filter phase and the centre phase alternate, so the design also assumes two strobes never fall on consecutive clocks.
- R3: Input and output codes are offset binary. Code 512 means zero, and the conversion to and from two's complement flips only bit 9.
- R4: Take a sample whose strobe is captured at clock edge E. On edge E+4, `out_code` becomes the sample captured ten strobes earlier, bit for bit. An isolated impulse therefore reappears unchanged 24 clocks after its own strobe edge, and this is the peak of the response.
- R5: On edge E+3, `out_code` becomes the filter phase. The sum runs over i = 0..10 of K(10-i) * (x[k-i] + x[k-21+i]), where x[k] is the sample captured at E and x[k-j] the one captured j strobes earlier. The sum is then rounded and clamped.
- R6: The tap weights K(0)..K(10), from the tap next to the centre outward, are 10343, -3224, 1688, -979, 572, -322, 170, -81, 33, -10, 2. The centre tap is 16384, so all taps are scaled by 2^14.
- R7: Each polyphase branch sums to 16384. A constant input code therefore returns the same code on both output phases once the history is full of it.
- R8: Rounding adds 8192 to the full-precision sum and then shifts it arithmetically right by 14 bits. Halves round toward plus infinity.
- R9: A rounded result above 511 yields code 1023, and one below -512 yields code 0. The output never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output-rate clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input strobe, high on every second clock |
| in_code | input | 10 | Offset-binary input sample, taken when `in_valid` is high |
| out_code | output | 10 | Offset-binary output sample, one per clock |

## Verification
For a strobe captured at clock edge E, the filter-phase result is due after edge E+3 and the centre-phase result after edge E+4. A lone impulse therefore peaks 24 clocks after its own edge. The bench counts rising edges. On each strobe it computes both expected results from its own history of samples and files them under edge numbers E+3 and E+4. On every falling edge it compares `out_code` with whatever is filed for the edge just passed. Direct checks on the impulse peak, the constant-input gain and the idle mid-scale output use the same scheduling.

// File: rtl/hbi_pkg.sv
// Package: hbi_pkg
// Shared sizes and the fixed tap set of the half-band interpolator.
// Assumes the weights are scaled by 2^COEF_FRAC and the centre tap equals 2^COEF_FRAC.
package hbi_pkg;
    localparam int SAMPLE_W   = 10;
    localparam int COEF_W     = 16;
    localparam int COEF_FRAC  = 14;
    localparam int PAIRS      = 11;
    localparam int HIST_LEN   = 2 * PAIRS;
    localparam int CENTRE_POS = PAIRS - 1;
    localparam int TAP_COUNT  = 4 * PAIRS - 1;

    // Weight of the tap pair at odd distance 2*m+1 from the centre.
    function automatic logic signed [COEF_W-1:0] arm_coef(input int m);
        case (m)
            0:       return 16'sd10343;
            1:       return -16'sd3224;
            2:       return 16'sd1688;
            3:       return -16'sd979;
            4:       return 16'sd572;
            5:       return -16'sd322;
            6:       return 16'sd170;
            7:       return -16'sd81;
            8:       return 16'sd33;
            9:       return -16'sd10;
            10:      return 16'sd2;
            default: return 16'sd0;
        endcase
    endfunction
endpackage

// File: rtl/hbi_tapline.sv
// Module: hbi_tapline
// Holds the last HIST sample values in two's complement. Each strobe shifts in one sample.
// Forms the symmetric pair sums (newest+oldest, ...) and taps out the middle sample.
// Assumes load is high for a single clock per input sample.
module hbi_tapline #(
    parameter int W     = hbi_pkg::SAMPLE_W,
    parameter int PAIRS = hbi_pkg::PAIRS,
    localparam int HIST = 2 * PAIRS,
    localparam int PW   = W + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic signed [W-1:0]  din,
    output logic signed [PW-1:0] pair_sum [PAIRS],
    output logic signed [W-1:0]  centre
);
    logic signed [W-1:0] hist_q [HIST];

    // Shift the history by one place on each strobe; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < HIST; j++) hist_q[j] <= '0;
        end else if (load) begin
            hist_q[0] <= din;
            for (int j = 1; j < HIST; j++) hist_q[j] <= hist_q[j-1];
        end
    end

    // Pre-add mirrored taps so that each weight needs one multiplier.
    generate
        for (genvar i = 0; i < PAIRS; i++) begin : g_pair
            assign pair_sum[i] = PW'(hist_q[i]) + PW'(hist_q[HIST-1-i]);
        end
    endgenerate

    // The middle sample feeds the centre phase.
    assign centre = hist_q[PAIRS-1];

    // R2: a strobe places the new sample at the head and moves the old head one place down.
    p_load_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (hist_q[0] == $past(din)) && (hist_q[1] == $past(hist_q[0])));

    // R2: without a strobe the history stays put.
    p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(hist_q[0]) && $stable(hist_q[HIST-1]));
endmodule

// File: rtl/hbi_mac.sv
// Module: hbi_mac
// Multiplies each pair sum by its fixed weight in one register stage.
// Adds the products at full precision in a second stage.
// Delays the centre sample by the same two stages.
// Assumes the pair sums stay stable for two clocks after each strobe.
module hbi_mac #(
    parameter int W      = hbi_pkg::SAMPLE_W,
    parameter int CW     = hbi_pkg::COEF_W,
    parameter int PAIRS  = hbi_pkg::PAIRS,
    localparam int PW    = W + 1,
    localparam int PRODW = PW + CW,
    localparam int ACCW  = PRODW + $clog2(PAIRS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [PW-1:0]    pair_sum [PAIRS],
    input  logic signed [W-1:0]     centre_in,
    output logic signed [ACCW-1:0]  acc_q,
    output logic signed [W-1:0]     centre_q
);
    logic signed [CW-1:0]    k_w    [PAIRS];
    logic signed [PRODW-1:0] prod_q [PAIRS];
    logic signed [ACCW-1:0]  acc_d;
    logic signed [W-1:0]     mid_q;

    // Pair i joins history slots i and HIST-1-i, which lie 2*(PAIRS-1-i)+1 taps from the centre.
    generate
        for (genvar i = 0; i < PAIRS; i++) begin : g_coef
            assign k_w[i] = hbi_pkg::arm_coef(PAIRS - 1 - i);
        end
    endgenerate

    // Stage 1: register one product per weight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < PAIRS; i++) prod_q[i] <= '0;
        end else begin
            for (int i = 0; i < PAIRS; i++)
                prod_q[i] <= PRODW'(pair_sum[i]) * PRODW'(k_w[i]);
        end
    end

    // Full-precision sum of the registered products.
    always_comb begin
        acc_d = '0;
        for (int i = 0; i < PAIRS; i++) acc_d = acc_d + ACCW'(prod_q[i]);
    end

    // Stage 2: register the sum; the centre sample travels alongside it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q    <= '0;
            mid_q    <= '0;
            centre_q <= '0;
        end else begin
            acc_q    <= acc_d;
            mid_q    <= centre_in;
            centre_q <= mid_q;
        end
    end
endmodule

// File: rtl/hbi_round_sat.sv
// Module: hbi_round_sat
// Rounds a full-precision sum half-up to the sample grid and clamps it to W signed bits.
// Assumes the sum is scaled by 2^FRAC and that adding the rounding constant cannot overflow ACCW bits.
module hbi_round_sat #(
    parameter int W    = hbi_pkg::SAMPLE_W,
    parameter int FRAC = hbi_pkg::COEF_FRAC,
    parameter int ACCW = 32
) (
    input  logic signed [ACCW-1:0] acc,
    output logic signed [W-1:0]    y
);
    localparam logic signed [ACCW-1:0] HALF  = ACCW'(2 ** (FRAC - 1));
    localparam logic signed [ACCW-1:0] VMAX  = ACCW'(2 ** (W - 1) - 1);
    localparam logic signed [ACCW-1:0] VMIN  = -ACCW'(2 ** (W - 1));

    logic signed [ACCW-1:0] rnd;
    logic signed [ACCW-1:0] shifted;

    // Add half an output step, drop the fraction, then clamp without wrapping.
    always_comb begin
        rnd     = acc + HALF;
        shifted = rnd >>> FRAC;
        if (shifted > VMAX)      y = VMAX[W-1:0];
        else if (shifted < VMIN) y = VMIN[W-1:0];
        else                     y = shifted[W-1:0];
    end
endmodule

// File: rtl/halfband_interp2.sv
// Module: halfband_interp2
// Two-times half-band interpolator. Takes one offset-binary sample every second clock
// and writes one offset-binary sample every clock.
// A strobe captured at edge E yields the filter phase at E+3 and the centre phase at E+4.
// Assumes in_valid is high on exactly every second clock.
module halfband_interp2 #(
    parameter int SAMPLE_W  = hbi_pkg::SAMPLE_W,
    parameter int COEF_W    = hbi_pkg::COEF_W,
    parameter int COEF_FRAC = hbi_pkg::COEF_FRAC,
    parameter int PAIRS     = hbi_pkg::PAIRS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_code,
    output logic [SAMPLE_W-1:0] out_code
);
    localparam int PW    = SAMPLE_W + 1;
    localparam int PRODW = PW + COEF_W;
    localparam int ACCW  = PRODW + $clog2(PAIRS);
    localparam logic signed [SAMPLE_W-1:0] SAT_MAX = SAMPLE_W'(2 ** (SAMPLE_W - 1) - 1);
    localparam logic signed [SAMPLE_W-1:0] SAT_MIN = -SAMPLE_W'(2 ** (SAMPLE_W - 1));
    localparam logic signed [ACCW-1:0] HI_TRIP =
        ACCW'(2 ** (SAMPLE_W - 1)) * ACCW'(2 ** COEF_FRAC) - ACCW'(2 ** (COEF_FRAC - 1));
    localparam logic signed [ACCW-1:0] LO_TRIP =
        -(ACCW'(2 ** (SAMPLE_W - 1)) * ACCW'(2 ** COEF_FRAC)) - ACCW'(2 ** (COEF_FRAC - 1));

    logic signed [SAMPLE_W-1:0] din_tc;
    logic signed [PW-1:0]       pair_sum [PAIRS];
    logic signed [SAMPLE_W-1:0] centre_w;
    logic signed [ACCW-1:0]     acc_q;
    logic signed [SAMPLE_W-1:0] centre_q;
    logic signed [SAMPLE_W-1:0] fir_y;
    logic signed [SAMPLE_W-1:0] out_tc;
    logic                       ph_load, ph_mul, ph_acc;

    // Offset binary to two's complement: flip the top bit.
    assign din_tc = {~in_code[SAMPLE_W-1], in_code[SAMPLE_W-2:0]};

    hbi_tapline #(.W(SAMPLE_W), .PAIRS(PAIRS)) u_tapline (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (in_valid),
        .din      (din_tc),
        .pair_sum (pair_sum),
        .centre   (centre_w)
    );

    hbi_mac #(.W(SAMPLE_W), .CW(COEF_W), .PAIRS(PAIRS)) u_mac (
        .clk       (clk),
        .rst_n     (rst_n),
        .pair_sum  (pair_sum),
        .centre_in (centre_w),
        .acc_q     (acc_q),
        .centre_q  (centre_q)
    );

    hbi_round_sat #(.W(SAMPLE_W), .FRAC(COEF_FRAC), .ACCW(ACCW)) u_round_sat (
        .acc (acc_q),
        .y   (fir_y)
    );

    // Phase tracker: marks the clock in which the sum for the newest strobe sits in acc_q.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_load <= 1'b0;
            ph_mul  <= 1'b0;
            ph_acc  <= 1'b0;
        end else begin
            ph_load <= in_valid;
            ph_mul  <= ph_load;
            ph_acc  <= ph_mul;
        end
    end

    // Output register: the filter phase follows a fresh sum, otherwise the centre phase.
    always_ff @(posedge clk) begin
        if (!rst_n) out_tc <= '0;
        else        out_tc <= ph_acc ? fir_y : centre_q;
    end

    // Two's complement back to offset binary.
    assign out_code = {~out_tc[SAMPLE_W-1], out_tc[SAMPLE_W-2:0]};

    // R2: strobes never fall on consecutive clocks.
    p_strobe_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> !in_valid);

    // R2: the filter phase is followed by the centre phase.
    p_phase_alternates_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ph_acc |=> !ph_acc);

    // R9: a sum that rounds above full scale lands on the top code.
    p_clamp_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_acc && (acc_q >= HI_TRIP)) |=> (out_tc == SAT_MAX));

    // R9: a sum that rounds below full scale lands on the bottom code.
    p_clamp_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_acc && (acc_q < LO_TRIP)) |=> (out_tc == SAT_MIN));
endmodule

// File: tb/halfband_interp2_tb.sv
module halfband_interp2_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [9:0] in_code = 10'd512;
    logic [9:0] out_code;

    int n_checks = 0;
    int n_fail = 0;
    int n_clamped = 0;
    int pcount = 0;
    bit started = 0;
    bit done = 0;

    int    exp_val [int];
    string exp_tag [int];
    int    dir_val [int];
    string dir_tag [int];
    int    hist [$];
    int    wt [11] = '{10343, -3224, 1688, -979, 572, -322, 170, -81, 33, -10, 2};

    halfband_interp2 u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_code  (in_code),
        .out_code (out_code)
    );

    always #10 clk = ~clk;
    always @(posedge clk) pcount <= pcount + 1;

    task automatic check(input string tag, input int actual, input int expected, input int cyc);
        n_checks++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s edge %0d: out_code=%0d expected %0d", tag, cyc, actual, expected);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    endtask

    // Compare out_code with everything filed for the edge just passed.
    task automatic check_now();
        int t = pcount;
        if (t < 1) return;
        if (exp_val.exists(t)) begin
            started = 1;
            check(exp_tag[t], int'(out_code), exp_val[t], t);
            exp_val.delete(t);
        end else if (!started) begin
            check("R1 idle mid-scale", int'(out_code), 512, t);
        end
        if (dir_val.exists(t)) begin
            check(dir_tag[t], int'(out_code), dir_val[t], t);
            dir_val.delete(t);
        end
    endtask

    // Reference model: push one sample; file filter phase at E+3 and centre phase at E+4.
    task automatic model_push(input int code, input int t);
        longint acc;
        longint r;
        int     ev;
        string  tg;
        hist.push_front(code - 512);
        if (hist.size() > 22) void'(hist.pop_back());
        acc = 0;
        for (int i = 0; i < 11; i++) acc += longint'(wt[10 - i]) * (hist[i] + hist[21 - i]);
        r  = (acc + 8192) >>> 14;
        tg = "R5 R6 R8 filter phase";
        if (r > 511)       begin r = 511;  tg = "R9 clamp high"; n_clamped++; end
        else if (r < -512) begin r = -512; tg = "R9 clamp low";  n_clamped++; end
        ev = int'(r) + 512;
        exp_val[t + 4] = ev;
        exp_tag[t + 4] = tg;
        exp_val[t + 5] = hist[10] + 512;
        exp_tag[t + 5] = "R4 centre phase";
    endtask

    // One clock: check, then drive. A strobe driven at falling edge t is captured at edge t+1.
    task automatic step(input bit strobe, input int code);
        @(negedge clk);
        check_now();
        in_valid = strobe;
        in_code  = 10'(code);
        if (strobe) model_push(code, pcount);
    endtask

    task automatic sample(input int code);
        step(1'b1, code);
        step(1'b0, 512);
    endtask

    initial begin
        for (int i = 0; i < 22; i++) hist.push_back(0);
    end

    // Watchdog: a hung run counts as a failed check and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not end, actual running expected finished");
            finish_run();
        end
    end

    initial begin
        int lfsr;
        int t_imp;
        // R1: reset held, output at mid-scale.
        repeat (4) step(1'b0, 512);
        rst_n = 1'b1;
        repeat (4) step(1'b0, 512);
        // Prime with zeros (code 512).
        for (int i = 0; i < 22; i++) sample(512);
        // R3 R4: impulse of +256 (code 768) returns exactly at its peak 24 clocks after its edge.
        @(negedge clk);
        check_now();
        in_valid = 1'b1;
        in_code  = 10'd768;
        t_imp    = pcount;
        model_push(768, t_imp);
        dir_val[t_imp + 25] = 768;
        dir_tag[t_imp + 25] = "R3 R4 impulse peak";
        step(1'b0, 512);
        for (int i = 0; i < 30; i++) sample(512);
        // R7: a constant code comes back unchanged on both phases.
        for (int i = 0; i < 35; i++) begin
            if (i == 34) begin
                @(negedge clk);
                check_now();
                in_valid = 1'b1;
                in_code  = 10'd900;
                model_push(900, pcount);
                dir_val[pcount + 4] = 900;
                dir_tag[pcount + 4] = "R7 unity gain filter phase";
                dir_val[pcount + 5] = 900;
                dir_tag[pcount + 5] = "R7 unity gain centre phase";
                step(1'b0, 512);
            end else begin
                sample(900);
            end
        end
        // R9: full-scale steps both ways overshoot and must clamp.
        for (int i = 0; i < 30; i++) sample(0);
        for (int i = 0; i < 30; i++) sample(1023);
        for (int i = 0; i < 30; i++) sample(0);
        for (int i = 0; i < 30; i++) sample(1023);
        // R5 R8: pseudo-random codes.
        lfsr = 16'hACE1;
        for (int i = 0; i < 200; i++) begin
            lfsr = (lfsr >> 1) ^ ((lfsr & 1) != 0 ? 16'hB400 : 16'h0000);
            sample(lfsr & 1023);
        end
        repeat (6) step(1'b0, 512);
        // R9: the step segments must have driven the clamp.
        n_checks++;
        if (n_clamped == 0) begin
            n_fail++;
            $display("FAIL R9 clamp exercised: actual %0d expected >0", n_clamped);
        end
        done = 1;
        finish_run();
    end
endmodule